// File: doc/BRIEF.md
# Branch Target Buffer with Return Stack

This block predicts control flow at the fetch stage. The fetch address indexes a direct-mapped table. In the same cycle the block reports whether the selected entry was written by the branch at this exact address, whether that branch is expected to be taken, and where it goes. Each entry keeps a 2-bit saturating counter, so one odd outcome does not flip the predicted direction.

Return instructions do not take their target from the table. An eight-entry circular stack holds return addresses. It is pushed when a call resolves and popped when a return resolves.

The execute stage drives a single update port with the resolved address, outcome, target and kind of each control-flow instruction. Writes land on the clock edge that ends the update cycle. A lookup in that same cycle still sees the old contents.

Top module: `btb_predictor`

## Requirements
- R1: After reset every table entry is invalid and the return stack is empty, so every lookup reports no hit.
- R2: The entry index is fetch address bits [5:2] (16 entries, 4-byte instructions). A hit also needs every other address bit to equal the address stored with the entry, so an address that only shares the index misses.
- R3: On a miss, `pred_taken_o` is 0 and both `pred_target_o` and `pred_next_pc_o` equal the fetch address plus 4.
- R4: A resolution that misses the table allocates an entry only when the instruction was taken. A new entry starts in the weakly-taken state.
- R5: The counter encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. Each resolution that hits moves the counter one step toward its outcome and saturates at 00 and 11. A hit on a non-return entry predicts taken exactly when bit 1 is set. `pred_next_pc_o` is the target when the prediction is taken and the address plus 4 when it is not.
- R6: Starting from a strong state, the predicted direction changes only after two consecutive opposite outcomes.
- R7: A taken resolution that hits replaces the stored target. A not-taken resolution leaves the stored target unchanged.
- R8: Table and stack writes take effect on the clock edge that ends the update cycle. A lookup in that cycle sees the old contents.
- R9: `upd_kind_i` encodes 00 plain branch, 01 call, 10 return. A resolved call pushes its own address plus 4. A hit on a return entry predicts taken, with the stack top as target.
- R10: The stack holds 8 addresses. A push onto a full stack overwrites the oldest address, so after 10 calls the 8 most recent come back in reverse order.
- R11: A pop on an empty stack leaves it empty. A return lookup with an empty stack predicts not-taken with target equal to the address plus 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | 32 | Fetch address to look up |
| pred_hit_o | output | 1 | Selected entry belongs to this address |
| pred_taken_o | output | 1 | Predicted taken |
| pred_target_o | output | 32 | Predicted target address |
| pred_next_pc_o | output | 32 | Predicted next fetch address |
| upd_valid_i | input | 1 | A resolved control-flow instruction is presented |
| upd_pc_i | input | 32 | Address of the resolved instruction |
| upd_taken_i | input | 1 | Resolved outcome |
| upd_target_i | input | 32 | Resolved target address |
| upd_kind_i | input | 2 | 00 branch, 01 call, 10 return |

## Verification
The bench reads every table index in four phases: after reset, after not-taken resolutions that must allocate nothing, after taken allocations, and with aliasing addresses. These phases separate a missing valid bit from a wrong allocation rule or a short tag. Several outcome bit patterns are then driven into one entry while the same address is looked up in each cycle. This covers saturation, the two-miss hysteresis, target refresh and the old-contents timing of a same-cycle lookup. Finally, a run of ten calls followed by nine returns checks the stack's LIFO order, the overwrite on overflow and a pop on an empty stack.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  typedef enum logic [1:0] {
    KIND_BR   = 2'b00,
    KIND_CALL = 2'b01,
    KIND_RET  = 2'b10,
    KIND_RSV  = 2'b11
  } kind_e;

  function automatic ctr_e ctr_step(input ctr_e c, input logic taken);
    ctr_e n;
    n = c;
    unique case (c)
      CTR_SNT: n = taken ? CTR_WNT : CTR_SNT;
      CTR_WNT: n = taken ? CTR_WT  : CTR_SNT;
      CTR_WT:  n = taken ? CTR_ST  : CTR_WNT;
      CTR_ST:  n = taken ? CTR_ST  : CTR_WT;
      default: n = CTR_WT;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/bp_table.sv
module bp_table
  import bp_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 4,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_pc_i,
  output logic              lk_hit_o,
  output logic              lk_taken_o,
  output logic              lk_ret_o,
  output logic [ADDR_W-1:0] lk_target_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i,
  input  logic              upd_ret_i,
  input  logic [ADDR_W-1:0] upd_target_i
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int OFS_W   = $clog2(INSTR_BYTES);
  localparam int TAG_W   = ADDR_W - IDX_W;

  logic              valid_q  [ENTRIES];
  logic [TAG_W-1:0]  tag_q    [ENTRIES];
  ctr_e              ctr_q    [ENTRIES];
  logic [ADDR_W-1:0] target_q [ENTRIES];
  logic              ret_q    [ENTRIES];

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] pc);
    return pc[OFS_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] pc);
    return {pc[ADDR_W-1:OFS_W+IDX_W], pc[OFS_W-1:0]};
  endfunction

  // lookup
  logic [IDX_W-1:0] l_idx;
  always_comb begin
    l_idx       = idx_of(lk_pc_i);
    lk_hit_o    = valid_q[l_idx] && (tag_q[l_idx] == tag_of(lk_pc_i));
    lk_taken_o  = ctr_q[l_idx][1];
    lk_ret_o    = ret_q[l_idx];
    lk_target_o = target_q[l_idx];
  end

  // update
  logic [IDX_W-1:0] u_idx;
  logic [TAG_W-1:0] u_tag;
  logic             u_hit, wr_ctr, wr_tgt;
  ctr_e             ctr_new;
  always_comb begin
    u_idx   = idx_of(upd_pc_i);
    u_tag   = tag_of(upd_pc_i);
    u_hit   = valid_q[u_idx] && (tag_q[u_idx] == u_tag);
    wr_ctr  = upd_valid_i && (u_hit || upd_taken_i);
    wr_tgt  = upd_valid_i && upd_taken_i;
    ctr_new = u_hit ? ctr_step(ctr_q[u_idx], upd_taken_i) : CTR_WT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENTRIES; e++) begin
        valid_q[e]  <= 1'b0;
        tag_q[e]    <= '0;
        ctr_q[e]    <= CTR_WNT;
        target_q[e] <= '0;
        ret_q[e]    <= 1'b0;
      end
    end else begin
      if (wr_ctr) ctr_q[u_idx] <= ctr_new;
      if (wr_tgt) begin
        valid_q[u_idx]  <= 1'b1;
        tag_q[u_idx]    <= u_tag;
        target_q[u_idx] <= upd_target_i;
        ret_q[u_idx]    <= upd_ret_i;
      end
    end
  end

  // R4
  alloc_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i && !u_hit) |=>
      (valid_q[$past(u_idx)] && ctr_q[$past(u_idx)] == CTR_WT));

  // R4
  no_alloc_nt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i && !u_hit) |=>
      (valid_q[$past(u_idx)] == $past(valid_q[u_idx]) &&
       tag_q[$past(u_idx)] == $past(tag_q[u_idx])));

  // R5
  ctr_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && u_hit && upd_taken_i && ctr_q[u_idx] == CTR_ST) |=>
      (ctr_q[$past(u_idx)] == CTR_ST));

  // R7
  tgt_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i) |=>
      (target_q[$past(u_idx)] == $past(target_q[u_idx])));
endmodule

// File: rtl/bp_ras.sv
module bp_ras #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  output logic [ADDR_W-1:0] top_o,
  output logic              valid_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] stk_q [DEPTH];
  logic [PTR_W-1:0]  ptr_q;   // next free slot
  logic [CNT_W-1:0]  cnt_q;
  logic [PTR_W-1:0]  top_idx, ptr_inc;

  always_comb begin
    top_idx = (ptr_q == '0) ? PTR_MAX : ptr_q - 1'b1;
    ptr_inc = (ptr_q == PTR_MAX) ? '0 : ptr_q + 1'b1;
    top_o   = stk_q[top_idx];
    valid_o = (cnt_q != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) stk_q[e] <= '0;
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (push_i) begin
      stk_q[ptr_q] <= push_addr_i;
      ptr_q        <= ptr_inc;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;   // full: oldest overwritten
    end else if (pop_i && valid_o) begin
      ptr_q <= top_idx;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R10
  ras_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);

  // R11
  ras_empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !valid_o) |=> !valid_o);

  // R9
  ras_push_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (valid_o && top_o == $past(push_addr_i)));

  // R9
  ras_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
endmodule

// File: rtl/bp_pred_mux.sv
module bp_pred_mux #(
  parameter int ADDR_W      = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              hit_i,
  input  logic              ctr_taken_i,
  input  logic              is_ret_i,
  input  logic [ADDR_W-1:0] tbl_target_i,
  input  logic              ras_valid_i,
  input  logic [ADDR_W-1:0] ras_top_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o,
  output logic [ADDR_W-1:0] next_pc_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  logic [ADDR_W-1:0] seq_pc;
  always_comb begin
    seq_pc = pc_i + STEP;
    if (!hit_i) begin
      taken_o  = 1'b0;
      target_o = seq_pc;
    end else if (is_ret_i) begin
      taken_o  = ras_valid_i;
      target_o = ras_valid_i ? ras_top_i : seq_pc;
    end else begin
      taken_o  = ctr_taken_i;
      target_o = tbl_target_i;
    end
    next_pc_o = taken_o ? target_o : seq_pc;
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import bp_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 4,
  parameter int INSTR_BYTES = 4,
  parameter int RAS_DEPTH   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  output logic              pred_hit_o,
  output logic              pred_taken_o,
  output logic [ADDR_W-1:0] pred_target_o,
  output logic [ADDR_W-1:0] pred_next_pc_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  logic [1:0]        upd_kind_i
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  kind_e             kind;
  logic              is_call, is_ret;
  logic              tbl_hit, tbl_taken, tbl_ret, ras_valid;
  logic [ADDR_W-1:0] tbl_target, ras_top;

  always_comb begin
    kind    = kind_e'(upd_kind_i);
    is_call = upd_valid_i && (kind == KIND_CALL);
    is_ret  = upd_valid_i && (kind == KIND_RET);
  end

  bp_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .INSTR_BYTES(INSTR_BYTES)) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lk_pc_i      (fetch_pc_i),
    .lk_hit_o     (tbl_hit),
    .lk_taken_o   (tbl_taken),
    .lk_ret_o     (tbl_ret),
    .lk_target_o  (tbl_target),
    .upd_valid_i  (upd_valid_i),
    .upd_pc_i     (upd_pc_i),
    .upd_taken_i  (upd_taken_i),
    .upd_ret_i    (kind == KIND_RET),
    .upd_target_i (upd_target_i)
  );

  bp_ras #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (is_call),
    .pop_i       (is_ret),
    .push_addr_i (upd_pc_i + STEP),
    .top_o       (ras_top),
    .valid_o     (ras_valid)
  );

  bp_pred_mux #(.ADDR_W(ADDR_W), .INSTR_BYTES(INSTR_BYTES)) u_mux (
    .pc_i         (fetch_pc_i),
    .hit_i        (tbl_hit),
    .ctr_taken_i  (tbl_taken),
    .is_ret_i     (tbl_ret),
    .tbl_target_i (tbl_target),
    .ras_valid_i  (ras_valid),
    .ras_top_i    (ras_top),
    .taken_o      (pred_taken_o),
    .target_o     (pred_target_o),
    .next_pc_o    (pred_next_pc_o)
  );

  assign pred_hit_o = tbl_hit;

  // R3
  taken_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_taken_o |-> pred_hit_o);

  // R3
  miss_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_hit_o |-> (pred_next_pc_o == fetch_pc_i + STEP && pred_target_o == fetch_pc_i + STEP));

  // R11
  ret_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_hit && tbl_ret && !ras_valid) |-> !pred_taken_o);
endmodule

// File: tb/btb_predictor_test.sv
module btb_predictor_test;
  localparam int AW = 32;
  localparam int N  = 16;
  localparam int D  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic          p_hit, p_taken;
  logic [AW-1:0] p_tgt, p_next;
  logic          uv = 1'b0;
  logic [AW-1:0] upc = '0;
  logic          utk = 1'b0;
  logic [AW-1:0] utgt = '0;
  logic [1:0]    ukind = 2'b00;

  int checks = 0;
  int failures = 0;

  // reference model state
  logic          m_valid [N];
  logic [AW-1:0] m_pc    [N];
  int            m_ctr   [N];
  logic [AW-1:0] m_tgt   [N];
  logic          m_ret   [N];
  logic [AW-1:0] m_stk   [D];
  int            m_ptr = 0;
  int            m_cnt = 0;

  always #2 clk = ~clk;

  btb_predictor uut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .fetch_pc_i     (fetch_pc),
    .pred_hit_o     (p_hit),
    .pred_taken_o   (p_taken),
    .pred_target_o  (p_tgt),
    .pred_next_pc_o (p_next),
    .upd_valid_i    (uv),
    .upd_pc_i       (upc),
    .upd_taken_i    (utk),
    .upd_target_i   (utgt),
    .upd_kind_i     (ukind)
  );

  function automatic int idx_of(input logic [AW-1:0] pc);
    return int'((pc >> 2) % N);
  endfunction

  task automatic model_update();
    int i;
    logic h;
    i = idx_of(upc);
    h = m_valid[i] && (m_pc[i] == upc);
    if (uv) begin
      if (h) m_ctr[i] = utk ? ((m_ctr[i] < 3) ? m_ctr[i] + 1 : 3)
                            : ((m_ctr[i] > 0) ? m_ctr[i] - 1 : 0);
      if (utk) begin
        if (!h) m_ctr[i] = 2;
        m_valid[i] = 1'b1;
        m_pc[i]    = upc;
        m_tgt[i]   = utgt;
        m_ret[i]   = (ukind == 2'b10);
      end
      if (ukind == 2'b01) begin
        m_stk[m_ptr] = upc + 4;
        m_ptr = (m_ptr + 1) % D;
        if (m_cnt < D) m_cnt++;
      end else if (ukind == 2'b10 && m_cnt > 0) begin
        m_ptr = (m_ptr + D - 1) % D;
        m_cnt--;
      end
    end
  endtask

  // one cycle: drive, compare against model (old contents), then let the edge land
  task automatic cyc(input logic [AW-1:0] lpc, input logic v, input logic [AW-1:0] pc,
                     input logic tk, input logic [AW-1:0] tg, input logic [1:0] kd,
                     input string req);
    int i;
    logic e_hit, e_tk;
    logic [AW-1:0] e_tgt, e_next;
    @(negedge clk);
    fetch_pc = lpc; uv = v; upc = pc; utk = tk; utgt = tg; ukind = kd;
    #1;
    i = idx_of(lpc);
    e_hit = m_valid[i] && (m_pc[i] == lpc);
    e_tk  = 1'b0;
    e_tgt = lpc + 4;
    if (e_hit && m_ret[i]) begin
      if (m_cnt > 0) begin
        e_tk  = 1'b1;
        e_tgt = m_stk[(m_ptr + D - 1) % D];
      end
    end else if (e_hit) begin
      e_tk  = (m_ctr[i] >= 2);
      e_tgt = m_tgt[i];
    end
    e_next = e_tk ? e_tgt : lpc + 4;
    checks++;
    if (p_hit !== e_hit || p_taken !== e_tk || p_tgt !== e_tgt || p_next !== e_next) begin
      failures++;
      $display("FAIL %s pc=%h act hit=%b tk=%b tgt=%h nxt=%h exp hit=%b tk=%b tgt=%h nxt=%h",
               req, lpc, p_hit, p_taken, p_tgt, p_next, e_hit, e_tk, e_tgt, e_next);
    end
    @(posedge clk);
    model_update();
  endtask

  localparam logic [AW-1:0] BASE = 32'h0000_1000;
  localparam logic [AW-1:0] RPC  = 32'h0000_3000;

  initial begin
    #800000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 1'b0; m_pc[i] = '0; m_ctr[i] = 1; m_tgt[i] = '0; m_ret[i] = 1'b0;
    end
    for (int i = 0; i < D; i++) m_stk[i] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1 / R3: empty after reset
    for (int k = 0; k < N; k++) cyc(BASE + 4*k, 0, '0, 0, '0, 2'b00, "R1");
    // R4: not-taken misses allocate nothing
    for (int k = 0; k < N; k++) cyc(BASE + 4*k, 1, BASE + 4*k, 0, 32'h7000, 2'b00, "R4");
    for (int k = 0; k < N; k++) cyc(BASE + 4*k, 0, '0, 0, '0, 2'b00, "R3");
    // R8: allocate with same-cycle lookup of same address
    for (int k = 0; k < N; k++)
      cyc(BASE + 4*k, 1, BASE + 4*k, 1, 32'h8000 + 16*k, 2'b00, "R8");
    // R4: weakly taken after allocation
    for (int k = 0; k < N; k++) cyc(BASE + 4*k, 0, '0, 0, '0, 2'b00, "R4");
    // R2: aliases on the same index miss
    for (int k = 0; k < N; k++) cyc(BASE + 4*k + 64, 0, '0, 0, '0, 2'b00, "R2");
    for (int k = 0; k < N; k++) cyc(BASE + 4*k + 2, 0, '0, 0, '0, 2'b00, "R2");
    for (int k = 0; k < N; k++) cyc(BASE + 4*k + 32'h0010_0000, 0, '0, 0, '0, 2'b00, "R2");

    // R5: outcome patterns into one entry, looked up every cycle
    for (int p = 0; p < 4; p++) begin
      logic [15:0] pat;
      pat = 16'hA5C3 ^ 16'(p * 16'h1357);
      for (int b = 0; b < 16; b++)
        cyc(BASE + 4, 1, BASE + 4, pat[b], 32'h9000 + 4*b, 2'b00, "R5");
      cyc(BASE + 4, 0, '0, 0, '0, 2'b00, "R5");
    end

    // R6: strong taken needs two not-taken outcomes to flip
    cyc(BASE + 8, 1, BASE + 8, 1, 32'hA000, 2'b00, "R6");
    cyc(BASE + 8, 1, BASE + 8, 1, 32'hA000, 2'b00, "R6");
    cyc(BASE + 8, 1, BASE + 8, 0, 32'hBEE0, 2'b00, "R6");
    cyc(BASE + 8, 0, '0, 0, '0, 2'b00, "R6");
    cyc(BASE + 8, 1, BASE + 8, 0, 32'hBEE0, 2'b00, "R6");
    cyc(BASE + 8, 0, '0, 0, '0, 2'b00, "R6");
    // R7: not-taken keeps target, taken refreshes it
    cyc(BASE + 8, 1, BASE + 8, 1, 32'hC000, 2'b00, "R7");
    cyc(BASE + 8, 1, BASE + 8, 1, 32'hC100, 2'b00, "R7");
    cyc(BASE + 8, 0, '0, 0, '0, 2'b00, "R7");

    // R11: return entry with empty stack
    cyc(RPC, 1, RPC, 1, 32'hDEAD_0000, 2'b10, "R11");
    cyc(RPC, 0, '0, 0, '0, 2'b00, "R11");
    // R9 / R10: ten calls, then nine returns
    for (int k = 0; k < 10; k++)
      cyc(RPC, 1, 32'h0000_2004 + 4*k, 1, 32'h0000_5000, 2'b01, "R9");
    for (int k = 0; k < 9; k++)
      cyc(RPC, 1, RPC, 1, 32'hDEAD_0000, 2'b10, "R10");
    cyc(RPC, 1, RPC, 1, 32'hDEAD_0000, 2'b10, "R11");
    cyc(RPC, 0, '0, 0, '0, 2'b00, "R11");
    // R9: call after empty, visible next cycle
    cyc(RPC, 1, 32'h0000_2100, 1, 32'h0000_5000, 2'b01, "R9");
    cyc(RPC, 0, '0, 0, '0, 2'b00, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule